// File: doc/BRIEF.md
# Data-Transfer Instruction Sequencer

This block is a multi-cycle fetch-and-execute controller for an 8-bit processor core. It carries only the instructions that copy data: register to register, register to and from the memory location held in H/L, immediate byte and immediate 16-bit pair loads, accumulator load and store by a direct address or through the BC or DE pair, H/L load and store by a direct address, the swap of H/L with D/E, and port input and output. It keeps a 16-bit program counter and fetches the opcode and any operand bytes one per clock. Every bus access, whether a fetch, a data read, a data write or a port access, occupies exactly one clock. No instruction it runs touches any condition flag.

The block connects to a memory whose read data is valid in the same cycle as the address and whose writes take effect at the end of the strobed cycle. Port accesses use the same address and data lines with their own strobes. Opcodes outside the group are skipped as one-byte no-ops. The memory-to-memory move encoding halts the sequencer until reset.

Top module: `xfer_seq`

## Requirements
- R1: Reset clears the program counter and all registers (A, B, C, D, E, H, L and the 16-bit stack pointer) to zero; the first cycle after reset is an opcode fetch at address 0000 with only mem_rd high.
- R2: At most one of mem_rd, mem_wr, io_rd, io_wr is high in any cycle, and every bus access takes exactly one clock, so MVI r followed by a direct accumulator store takes 2 + 4 cycles.
- R3: MOV d,s (01dddsss, neither field 6) copies register s into register d in the single fetch cycle; register codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7, and code 6 means memory at address {H,L}.
- R4: MOV d,M reads the byte at {H,L} into d, and MOV M,s writes s to {H,L}; each takes a fetch plus one data cycle.
- R5: MVI (00ddd110) is two bytes; its second byte goes to register d, or to memory at {H,L} when d is 6.
- R6: LXI (00pp0001) is three bytes; byte 2 goes to the low register and byte 3 to the high register of pair pp (BC=0, DE=1, HL=2, SP=3); the stack pointer is visible on sp_q.
- R7: Direct accumulator load (3A) reads and store (32) writes the byte at address {byte 3, byte 2}.
- R8: Direct H/L load (2A) fills L from the given address and H from the address plus one; direct H/L store (22) writes L to the given address and H to the next one in the following cycle.
- R9: Indirect accumulator load (0A via BC, 1A via DE) and store (02 via BC, 12 via DE) are one byte and use the named pair as the address.
- R10: Exchange (EB) swaps H with D and L with E in one cycle.
- R11: IN (DB) and OUT (D3) are two bytes; the port number is driven on addr[7:0] and repeated on addr[15:8]; IN loads the port data into A, OUT drives A on dout with io_wr.
- R12: Any opcode outside the group is a one-byte no-op: the next byte is fetched as an opcode and no write strobe occurs.
- R13: Opcode 76 halts the sequencer: after its fetch no strobe is raised again until reset.
- R14: The program counter advances by one for each fetched opcode or operand byte, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | output | 16 | Memory or port address |
| din | input | 8 | Read data from memory or port |
| dout | output | 8 | Write data to memory or port |
| mem_rd | output | 1 | Memory read strobe (fetch or data read) |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| sp_q | output | 16 | Stack pointer value |

## Verification
Short programs are placed in a model memory and their effect is read back from memory and port traffic, since the registers are reached only through stores. Loading a distinct value into every register and storing each one separates the register codes and shows any mixed-up source or destination field. Pointer programs contrast BC, DE and HL addressing, and the exchange is detected by which address a later M write lands on. Interleaving unknown opcodes among real ones and counting writes and the cycle of the halting fetch shows whether instruction lengths and per-access timing are right.

// File: rtl/xfer_seq.sv
module xfer_seq (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        io_rd,
  output logic        io_wr,
  output logic [15:0] sp_q
);

  typedef enum logic [3:0] {
    S_FETCH = 4'd0, S_OP1 = 4'd1, S_OP2 = 4'd2, S_RD = 4'd3, S_RD2 = 4'd4,
    S_WR = 4'd5, S_WR2 = 4'd6, S_IN = 4'd7, S_OUT = 4'd8, S_HALT = 4'd9
  } st_t;

  localparam logic [2:0] RB = 3'd0, RC = 3'd1, RD = 3'd2, RE = 3'd3,
                         RH = 3'd4, RL = 3'd5, RM = 3'd6, RA = 3'd7;
  localparam logic [7:0] OP_LDA = 8'h3A, OP_STA = 8'h32, OP_LHLD = 8'h2A,
                         OP_SHLD = 8'h22, OP_XCHG = 8'hEB, OP_IN = 8'hDB,
                         OP_OUT = 8'hD3;

  st_t         st;
  logic [15:0] pc, ea, sp;
  logic [7:0]  ir, lo, wd;
  logic [2:0]  dst;
  logic [7:0]  rf [8];

  wire [15:0] hl = {rf[RH], rf[RL]};
  wire [15:0] bc = {rf[RB], rf[RC]};
  wire [15:0] de = {rf[RD], rf[RE]};
  wire is_mvi = (ir[7:6] == 2'b00) && (ir[2:0] == 3'b110);
  wire is_lxi = (ir[7:6] == 2'b00) && (ir[3:0] == 4'b0001);
  wire fetch_ph = (st == S_FETCH) || (st == S_OP1) || (st == S_OP2);

  assign addr   = fetch_ph ? pc : ((st == S_RD2 || st == S_WR2) ? ea + 16'd1 : ea);
  assign dout   = (st == S_WR2) ? rf[RH] : wd;
  assign mem_rd = fetch_ph || st == S_RD || st == S_RD2;
  assign mem_wr = (st == S_WR) || (st == S_WR2);
  assign io_rd  = (st == S_IN);
  assign io_wr  = (st == S_OUT);
  assign sp_q   = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= '0;
      ea  <= '0;
      sp  <= '0;
      ir  <= '0;
      lo  <= '0;
      wd  <= '0;
      dst <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          pc <= pc + 16'd1;
          ir <= din;
          casez (din)
            8'b01110110: st <= S_HALT;
            8'b01110???: begin ea <= hl; wd <= rf[din[2:0]]; st <= S_WR; end
            8'b01???110: begin ea <= hl; dst <= din[5:3]; st <= S_RD; end
            8'b01??????: rf[din[5:3]] <= rf[din[2:0]];
            8'b00???110, 8'b00??0001,
            OP_LDA, OP_STA, OP_LHLD, OP_SHLD, OP_IN, OP_OUT: st <= S_OP1;
            8'h0A: begin ea <= bc; dst <= RA; st <= S_RD; end
            8'h1A: begin ea <= de; dst <= RA; st <= S_RD; end
            8'h02: begin ea <= bc; wd <= rf[RA]; st <= S_WR; end
            8'h12: begin ea <= de; wd <= rf[RA]; st <= S_WR; end
            OP_XCHG: begin
              rf[RD] <= rf[RH]; rf[RH] <= rf[RD];
              rf[RE] <= rf[RL]; rf[RL] <= rf[RE];
            end
            default: ;
          endcase
        end
        S_OP1: begin
          pc <= pc + 16'd1;
          lo <= din;
          if (is_mvi) begin
            if (ir[5:3] == RM) begin ea <= hl; wd <= din; st <= S_WR; end
            else begin rf[ir[5:3]] <= din; st <= S_FETCH; end
          end else if (ir == OP_IN) begin
            ea <= {din, din}; st <= S_IN;
          end else if (ir == OP_OUT) begin
            ea <= {din, din}; wd <= rf[RA]; st <= S_OUT;
          end else begin
            st <= S_OP2;
          end
        end
        S_OP2: begin
          pc <= pc + 16'd1;
          st <= S_FETCH;
          if (is_lxi) begin
            case (ir[5:4])
              2'd0: begin rf[RB] <= din; rf[RC] <= lo; end
              2'd1: begin rf[RD] <= din; rf[RE] <= lo; end
              2'd2: begin rf[RH] <= din; rf[RL] <= lo; end
              default: sp <= {din, lo};
            endcase
          end else begin
            ea <= {din, lo};
            case (ir)
              OP_LDA:  begin dst <= RA; st <= S_RD; end
              OP_LHLD: begin dst <= RL; st <= S_RD; end
              OP_STA:  begin wd <= rf[RA]; st <= S_WR; end
              default: begin wd <= rf[RL]; st <= S_WR; end
            endcase
          end
        end
        S_RD: begin
          rf[dst] <= din;
          st <= (ir == OP_LHLD) ? S_RD2 : S_FETCH;
        end
        S_RD2: begin rf[RH] <= din; st <= S_FETCH; end
        S_WR:  st <= (ir == OP_SHLD) ? S_WR2 : S_FETCH;
        S_WR2: st <= S_FETCH;
        S_IN:  begin rf[RA] <= din; st <= S_FETCH; end
        S_OUT: st <= S_FETCH;
        default: st <= S_HALT;
      endcase
    end
  end

endmodule

module xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [15:0] pc,
  input logic [3:0]  st
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_rd && addr == 16'h0000 && !mem_wr && !io_rd && !io_wr));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  // R8
  pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> addr == $past(addr) + 16'd1);

  // R11
  port_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> addr[15:8] == addr[7:0]);

  // R13
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd9) |=> (st == 4'd9 && !mem_rd && !mem_wr && !io_rd && !io_wr));

  // R14
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> pc == $past(pc) + 16'd1);

endmodule

bind xfer_seq xfer_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .pc(pc), .st(st)
);

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr, sp_q;
  logic [7:0]  din, dout;
  logic        mem_rd, mem_wr, io_rd, io_wr;

  logic [7:0]  mem [4096];
  int          errors = 0, checks = 0;
  int          cyc, halt_cyc, post_halt, wr_count, tcnt = 0;
  logic [15:0] io_rd_addr, io_wr_addr;
  logic [7:0]  io_wr_data;
  int          ptr;

  always #2 clk = ~clk;

  xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .sp_q(sp_q)
  );

  assign din = io_rd ? (addr[7:0] ^ 8'h5A) : mem[addr[11:0]];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) begin mem[addr[11:0]] = dout; wr_count++; end
      if (io_wr) begin io_wr_addr = addr; io_wr_data = dout; end
      if (io_rd) io_rd_addr = addr;
      if (halt_cyc < 0 && mem_rd && din == 8'h76) halt_cyc = cyc;
      else if (halt_cyc >= 0 && (mem_rd || mem_wr || io_rd || io_wr)) post_halt++;
      cyc++;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start();
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    cyc = 0; halt_cyc = -1; post_halt = 0; wr_count = 0;
    io_rd_addr = '0; io_wr_addr = '0; io_wr_data = '0;
    ptr = 0;
  endtask

  task automatic put(input logic [7:0] b);
    mem[ptr] = b;
    ptr++;
  endtask

  task automatic go(input int n);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    start();
    mem[12'h100] = 8'hFF;
    put(8'h32); put(8'h00); put(8'h01); put(8'h76);
    @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    chk("R1 fetch addr", addr, 16'h0000);
    chk("R1 strobes", {12'h0, mem_rd, mem_wr, io_rd, io_wr}, 16'h0008);
    repeat (30) @(negedge clk);
    chk("R1 A cleared", {8'h0, mem[12'h100]}, 16'h0000);
    chk("R1 SP cleared", sp_q, 16'h0000);
  endtask

  task automatic t_regs();
    start();
    put(8'h3E); put(8'hA7); put(8'h06); put(8'hB0); put(8'h0E); put(8'hC1);
    put(8'h16); put(8'hD2); put(8'h1E); put(8'hE3); put(8'h26); put(8'h0B);
    put(8'h2E); put(8'h5A);
    put(8'h32); put(8'h00); put(8'h03);
    put(8'h78); put(8'h32); put(8'h01); put(8'h03);
    put(8'h79); put(8'h32); put(8'h02); put(8'h03);
    put(8'h7A); put(8'h32); put(8'h03); put(8'h03);
    put(8'h7B); put(8'h32); put(8'h04); put(8'h03);
    put(8'h7C); put(8'h32); put(8'h05); put(8'h03);
    put(8'h7D); put(8'h32); put(8'h06); put(8'h03);
    put(8'h45); put(8'h78); put(8'h32); put(8'h07); put(8'h03);
    put(8'h73);
    put(8'h76);
    go(120);
    chk("R5 MVI A", {8'h0, mem[12'h300]}, 16'h00A7);
    chk("R3 MOV A,B", {8'h0, mem[12'h301]}, 16'h00B0);
    chk("R3 MOV A,C", {8'h0, mem[12'h302]}, 16'h00C1);
    chk("R3 MOV A,D", {8'h0, mem[12'h303]}, 16'h00D2);
    chk("R3 MOV A,E", {8'h0, mem[12'h304]}, 16'h00E3);
    chk("R3 MOV A,H", {8'h0, mem[12'h305]}, 16'h000B);
    chk("R3 MOV A,L", {8'h0, mem[12'h306]}, 16'h005A);
    chk("R3 MOV B,L", {8'h0, mem[12'h307]}, 16'h005A);
    chk("R4 MOV M,E", {8'h0, mem[12'hB5A]}, 16'h00E3);
  endtask

  task automatic t_mem_ptr();
    start();
    put(8'h21); put(8'h00); put(8'h04);
    put(8'h36); put(8'h5C);
    put(8'h5E); put(8'h7B); put(8'h32); put(8'h01); put(8'h04);
    put(8'h76);
    go(40);
    chk("R5 MVI M", {8'h0, mem[12'h400]}, 16'h005C);
    chk("R4 MOV E,M", {8'h0, mem[12'h401]}, 16'h005C);
  endtask

  task automatic t_direct();
    start();
    mem[12'h510] = 8'h9D;
    mem[12'h600] = 8'h34; mem[12'h601] = 8'h12;
    put(8'h3A); put(8'h10); put(8'h05);
    put(8'h32); put(8'h20); put(8'h05);
    put(8'h2A); put(8'h00); put(8'h06);
    put(8'h22); put(8'h10); put(8'h06);
    put(8'h7C); put(8'h32); put(8'h20); put(8'h06);
    put(8'h76);
    go(50);
    chk("R7 LDA/STA", {8'h0, mem[12'h520]}, 16'h009D);
    chk("R8 SHLD low", {8'h0, mem[12'h610]}, 16'h0034);
    chk("R8 SHLD high", {8'h0, mem[12'h611]}, 16'h0012);
    chk("R8 LHLD into H", {8'h0, mem[12'h620]}, 16'h0012);
  endtask

  task automatic t_indirect();
    start();
    mem[12'h700] = 8'h66;
    put(8'h01); put(8'h00); put(8'h07);
    put(8'h11); put(8'h10); put(8'h07);
    put(8'h0A); put(8'h12);
    put(8'h3E); put(8'h77); put(8'h02);
    put(8'h1A); put(8'h32); put(8'h11); put(8'h07);
    put(8'h76);
    go(50);
    chk("R9 LDAX B/STAX D", {8'h0, mem[12'h710]}, 16'h0066);
    chk("R9 STAX B", {8'h0, mem[12'h700]}, 16'h0077);
    chk("R9 LDAX D", {8'h0, mem[12'h711]}, 16'h0066);
  endtask

  task automatic t_xchg();
    start();
    put(8'h21); put(8'h05); put(8'h08);
    put(8'h11); put(8'h10); put(8'h08);
    put(8'hEB);
    put(8'h36); put(8'hEE);
    put(8'h7B); put(8'h32); put(8'h20); put(8'h08);
    put(8'h31); put(8'h34); put(8'h12);
    put(8'h76);
    go(50);
    chk("R10 XCHG HL", {8'h0, mem[12'h810]}, 16'h00EE);
    chk("R10 XCHG old HL", {8'h0, mem[12'h805]}, 16'h0000);
    chk("R10 XCHG E", {8'h0, mem[12'h820]}, 16'h0005);
    chk("R6 LXI SP", sp_q, 16'h1234);
  endtask

  task automatic t_io();
    start();
    put(8'hDB); put(8'h3C);
    put(8'hD3); put(8'h81);
    put(8'h32); put(8'h00); put(8'h0B);
    put(8'h76);
    go(30);
    chk("R11 IN port addr", io_rd_addr, 16'h3C3C);
    chk("R11 OUT port addr", io_wr_addr, 16'h8181);
    chk("R11 OUT data", {8'h0, io_wr_data}, 16'h0066);
    chk("R11 IN to A", {8'h0, mem[12'hB00]}, 16'h0066);
  endtask

  task automatic t_unknown();
    start();
    put(8'h3E); put(8'h42);
    put(8'h80); put(8'hC3); put(8'h07);
    put(8'h32); put(8'h00); put(8'h09);
    put(8'h76);
    go(30);
    chk("R12 skip to STA", {8'h0, mem[12'h900]}, 16'h0042);
    chk("R12 write count", wr_count[15:0], 16'd1);
  endtask

  task automatic t_halt();
    start();
    put(8'h3E); put(8'h01);
    put(8'h32); put(8'h00); put(8'h0A);
    put(8'h76);
    put(8'h3E); put(8'h02);
    put(8'h32); put(8'h01); put(8'h0A);
    go(60);
    chk("R2 halt fetch cycle", halt_cyc[15:0], 16'd6);
    chk("R14 halt fetch addr reached", {8'h0, mem[12'hA00]}, 16'h0001);
    chk("R13 no access after halt", post_halt[15:0], 16'd0);
    chk("R13 later store skipped", {8'h0, mem[12'hA01]}, 16'h0000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      tcnt++;
      if (tcnt > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", tcnt);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    start();
    repeat (3) @(posedge clk);
    t_reset();
    t_regs();
    t_mem_ptr();
    t_direct();
    t_indirect();
    t_xchg();
    t_io();
    t_unknown();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule